// File: doc/BRIEF.md
# UART status flags and receive buffer

This block sits between the shift registers of a serial port and a processor bus. Bytes that the receiver finishes are queued in a two-entry receive FIFO. Each entry stores the byte together with its own frame-error and parity-error bits, so those bits always describe the character at the head of the queue. A single holding stage stands behind the FIFO; it plays the part of the receive shift register that is still holding a finished character. A data-overrun flag is raised when the FIFO and the holding stage are both occupied and another start bit is seen.

On the transmit side, one holding buffer takes a byte from the processor and passes it on to the transmitter. A transmit-complete flag reports that the last frame has left the line while nothing is waiting. The four flags (receive-complete, transmit-complete, data-register-empty, data-overrun) each drive an interrupt request through their own enable input. A byte-wide status register makes the flags and the head entry's error bits readable. Transmit-complete can be cleared through that register.

The processor data paths are valid/ready. The read side offers the head entry while `rd_valid` is high, and the entry is popped in the cycle where `rd_valid` and `rd_ready` are both high. The write side accepts a byte in the cycle where `tx_wr_valid` and `tx_wr_ready` are both high. A writer that sees `tx_wr_ready` low must hold its byte. The transmitter takes the held byte through `tx_out_valid`/`tx_out_ready`. The receiver's strobes cannot be back-pressured: a byte offered with nowhere to go is dropped.

Top module: `uart_flag_buffer`

## Requirements
- R1: After reset the status register reads 0x20, so only data-register-empty is set. `rd_valid`, `tx_out_valid` and all interrupt requests are low.
- R2: Receive-complete (status bit 7, also `rd_valid`) is high exactly while the FIFO holds an unread entry. Entries leave in arrival order, one per `rd_valid`&`rd_ready` cycle.
- R3: The head entry's frame-error bit appears on `rd_fe` and status bit 4. Its parity-error bit appears on `rd_pe` and status bit 2. After a pop, both show the next entry's bits.
- R4: An entry's parity-error bit is stored as one only if `par_chk_en` was high in the cycle the byte was received.
- R5: A byte that arrives while the FIFO is full goes into the holding stage. It enters the FIFO in the cycle of the next pop. A byte that arrives while the holding stage is occupied and no pop happens is discarded.
- R6: Data-overrun (status bit 3) sets on an `rx_start` pulse while the FIFO is full and the holding stage is occupied. It stays set until the next pop.
- R7: While `rx_en` is low, the FIFO and holding stage are emptied, data-overrun is cleared, and incoming bytes are ignored.
- R8: Data-register-empty (status bit 5) equals `tx_wr_ready`. An accepted byte appears on `tx_out_data` with `tx_out_valid` high until the transmitter takes it with `tx_out_ready`. At that point data-register-empty returns to one.
- R9: Transmit-complete (status bit 6) sets on a `tx_done` pulse while the holding buffer is empty. A `tx_done` while a byte is held leaves it unchanged. A set event beats a clear in the same cycle.
- R10: Transmit-complete clears on a `txc_ack` pulse, or on a status write with bit 6 equal to one. A status write with bit 6 equal to zero changes nothing, and no status write alters any other bit.
- R11: Each interrupt request is its flag ANDed with its enable: `irq_rxc`, `irq_txc`, `irq_udre` and `irq_dor`, using `ie_rxc`, `ie_txc`, `ie_udre` and `ie_dor`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low flushes the receive side |
| par_chk_en | input | 1 | Parity checking enabled for bytes received now |
| rx_start | input | 1 | Pulse: receiver detected a start bit |
| rx_byte_valid | input | 1 | Pulse: receiver finished a byte |
| rx_byte | input | 8 | Received byte |
| rx_fe | input | 1 | First stop bit of that byte sampled as zero |
| rx_pe | input | 1 | Parity mismatch on that byte |
| rd_valid | output | 1 | Head entry available |
| rd_ready | input | 1 | Processor reads (pops) the head entry |
| rd_data | output | 8 | Head entry byte |
| rd_fe | output | 1 | Head entry frame error |
| rd_pe | output | 1 | Head entry parity error |
| tx_wr_valid | input | 1 | Processor offers a byte to send |
| tx_wr_ready | output | 1 | Holding buffer empty |
| tx_wr_data | input | 8 | Byte to send |
| tx_out_valid | output | 1 | Byte waiting for the transmitter |
| tx_out_ready | input | 1 | Transmitter loads the byte |
| tx_out_data | output | 8 | Byte for the transmitter |
| tx_done | input | 1 | Pulse: frame fully shifted out |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register {rxc, txc, udre, fe, dor, pe, 0, 0} |
| txc_ack | input | 1 | Pulse: transmit-complete interrupt serviced |
| ie_rxc | input | 1 | Receive-complete interrupt enable |
| ie_txc | input | 1 | Transmit-complete interrupt enable |
| ie_udre | input | 1 | Data-register-empty interrupt enable |
| ie_dor | input | 1 | Data-overrun interrupt enable |
| irq_rxc | output | 1 | Receive-complete interrupt request |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_udre | output | 1 | Data-register-empty interrupt request |
| irq_dor | output | 1 | Data-overrun interrupt request |

## Verification
All sixteen combinations of frame error, raw parity error, parity enable and one further byte bit are pushed as pairs through the FIFO. This separates error bits that travel with their byte from error bits that are global, and it separates masked parity from raw parity. An overrun sequence fills the FIFO, then the holding stage, then sends a start pulse and a fourth byte. It tells apart a start bit with the holding stage empty, a start bit with it occupied, a dropped byte, and the hand-over of the held byte on a pop. The transmit side is driven through write, load and done. Transmit-complete is cleared once by acknowledge, once by a status write of one, and tried with a status write of zero. All sixteen interrupt-enable patterns are swept against a known flag state.

// File: rtl/uart_fb_pkg.sv
package uart_fb_pkg;
  localparam int BYTE_W = 8;
  localparam int CSR_W  = 8;

  // Status register bit positions
  localparam int RXC_BIT  = 7;
  localparam int TXC_BIT  = 6;
  localparam int UDRE_BIT = 5;
  localparam int FE_BIT   = 4;
  localparam int DOR_BIT  = 3;
  localparam int PE_BIT   = 2;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              fe;
    logic              pe;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/uart_fb_rx_fifo.sv
module uart_fb_rx_fifo
  import uart_fb_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  rx_entry_t       mem [DEPTH];
  logic [PW-1:0]   wptr, rptr;
  logic [CW-1:0]   count;
  logic            do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CMAX);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rptr];

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= inc(wptr);
      if (do_pop)  rptr <= inc(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (!flush && do_push && wptr == PW'(i))
        mem[i] <= push_entry;
    end
  end
endmodule

// File: rtl/uart_fb_rx_stage.sv
module uart_fb_rx_stage
  import uart_fb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_en,
  input  logic      in_valid,
  input  rx_entry_t in_entry,
  input  logic      start,
  input  logic      fifo_full,
  input  logic      pop,
  output logic      push,
  output rx_entry_t push_entry,
  output logic      overrun
);
  logic      hold_v;
  rx_entry_t hold_q;

  always_comb begin
    push       = 1'b0;
    push_entry = in_entry;
    if (rx_en) begin
      if (hold_v) begin
        if (pop) begin
          push       = 1'b1;
          push_entry = hold_q;
        end
      end else if (in_valid && (!fifo_full || pop)) begin
        push = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v  <= 1'b0;
      hold_q  <= '0;
      overrun <= 1'b0;
    end else if (!rx_en) begin
      hold_v  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (hold_v && pop) begin
        hold_v <= in_valid;
        if (in_valid) hold_q <= in_entry;
      end else if (!hold_v && in_valid && fifo_full && !pop) begin
        hold_v <= 1'b1;
        hold_q <= in_entry;
      end
      if (start && fifo_full && hold_v) overrun <= 1'b1;
      else if (pop)                     overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fb_tx_hold.sv
module uart_fb_tx_hold
  import uart_fb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  input  logic              done,
  input  logic              clr,
  output logic              txc
);
  logic hold_v;

  assign wr_ready  = !hold_v;
  assign out_valid = hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      out_data <= '0;
      txc      <= 1'b0;
    end else begin
      if (wr_valid && !hold_v) begin
        hold_v   <= 1'b1;
        out_data <= wr_data;
      end else if (hold_v && out_ready) begin
        hold_v <= 1'b0;
      end
      if (done && !hold_v) txc <= 1'b1;
      else if (clr)        txc <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_flag_buffer.sv
module uart_flag_buffer
  import uart_fb_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              par_chk_en,
  input  logic              rx_start,
  input  logic              rx_byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_fe,
  input  logic              rx_pe,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_fe,
  output logic              rd_pe,
  input  logic              tx_wr_valid,
  output logic              tx_wr_ready,
  input  logic [BYTE_W-1:0] tx_wr_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [BYTE_W-1:0] tx_out_data,
  input  logic              tx_done,
  input  logic              csr_wr,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  input  logic              txc_ack,
  input  logic              ie_rxc,
  input  logic              ie_txc,
  input  logic              ie_udre,
  input  logic              ie_dor,
  output logic              irq_rxc,
  output logic              irq_txc,
  output logic              irq_udre,
  output logic              irq_dor
);
  rx_entry_t in_entry, push_entry, head;
  logic      push, pop, empty, full, dor, txc, txc_clr;

  assign in_entry = '{data: rx_byte, fe: rx_fe, pe: rx_pe && par_chk_en};
  assign pop      = rd_valid && rd_ready;

  uart_fb_rx_stage u_stage (
    .clk, .rst_n, .rx_en,
    .in_valid   (rx_byte_valid),
    .in_entry   (in_entry),
    .start      (rx_start),
    .fifo_full  (full),
    .pop        (pop),
    .push       (push),
    .push_entry (push_entry),
    .overrun    (dor)
  );

  uart_fb_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
    .clk, .rst_n,
    .flush      (!rx_en),
    .push       (push),
    .push_entry (push_entry),
    .pop        (pop),
    .head       (head),
    .empty      (empty),
    .full       (full)
  );

  assign rd_valid = !empty;
  assign rd_data  = head.data;
  assign rd_fe    = head.fe && !empty;
  assign rd_pe    = head.pe && !empty;

  assign txc_clr = txc_ack || (csr_wr && csr_wdata[TXC_BIT]);

  uart_fb_tx_hold u_tx (
    .clk, .rst_n,
    .wr_valid  (tx_wr_valid),
    .wr_data   (tx_wr_data),
    .wr_ready  (tx_wr_ready),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data),
    .done      (tx_done),
    .clr       (txc_clr),
    .txc       (txc)
  );

  always_comb begin
    csr_rdata           = '0;
    csr_rdata[RXC_BIT]  = rd_valid;
    csr_rdata[TXC_BIT]  = txc;
    csr_rdata[UDRE_BIT] = tx_wr_ready;
    csr_rdata[FE_BIT]   = rd_fe;
    csr_rdata[DOR_BIT]  = dor;
    csr_rdata[PE_BIT]   = rd_pe;
  end

  assign irq_rxc  = rd_valid    && ie_rxc;
  assign irq_txc  = txc         && ie_txc;
  assign irq_udre = tx_wr_ready && ie_udre;
  assign irq_dor  = dor         && ie_dor;
endmodule

// File: rtl/uart_fb_checker.sv
module uart_fb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rx_start,
  input logic       rd_valid,
  input logic       tx_wr_valid,
  input logic       tx_wr_ready,
  input logic       tx_out_valid,
  input logic       tx_done,
  input logic       txc_ack,
  input logic [7:0] csr_rdata,
  input logic       irq_rxc,
  input logic       ie_rxc
);
  // R7: disabled receiver leaves nothing readable and no overrun
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rd_valid && !csr_rdata[3]));

  // R6: overrun only rises after a start pulse with data pending
  a_r6_dor_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rdata[3]) |-> ($past(rx_start) && $past(rd_valid)));

  // R9: transmit-complete only rises after done with an empty buffer
  a_r9_txc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rdata[6]) |-> ($past(tx_done) && $past(tx_wr_ready)));

  // R10: acknowledge without a new done clears transmit-complete
  a_r10_txc_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_ack && !tx_done) |=> !csr_rdata[6]);

  // R8: an accepted byte fills the buffer and is offered onward
  a_r8_take: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_valid && tx_wr_ready) |=> (!tx_wr_ready && tx_out_valid));

  // R11: receive interrupt needs both the flag and its enable
  a_r11_irq_rxc: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxc |-> (rd_valid && ie_rxc));
endmodule

bind uart_flag_buffer uart_fb_checker u_chk (.*);

// File: tb/test_uart_flag_buffer.sv
module test_uart_flag_buffer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic rx_en = 1, par_chk_en = 0, rx_start = 0, rx_byte_valid = 0;
  logic [7:0] rx_byte = 0;
  logic rx_fe = 0, rx_pe = 0, rd_ready = 0;
  logic rd_valid, rd_fe, rd_pe, tx_wr_ready, tx_out_valid;
  logic [7:0] rd_data, tx_out_data, csr_rdata;
  logic tx_wr_valid = 0, tx_out_ready = 0, tx_done = 0, csr_wr = 0, txc_ack = 0;
  logic [7:0] tx_wr_data = 0, csr_wdata = 0;
  logic ie_rxc = 0, ie_txc = 0, ie_udre = 0, ie_dor = 0;
  logic irq_rxc, irq_txc, irq_udre, irq_dor;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flag_buffer i_uart_flag_buffer (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rx_put(input logic [7:0] d, input logic fe, input logic pe);
    @(negedge clk);
    rx_byte = d; rx_fe = fe; rx_pe = pe; rx_byte_valid = 1;
    @(negedge clk);
    rx_byte_valid = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); rx_start = 1;
    @(negedge clk); rx_start = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_ready = 1;
    @(negedge clk); rd_ready = 0;
  endtask

  // expects head entry (d, fe, pe), then pops it
  task automatic expect_pop(input string req, input int d, input int fe, input int pe);
    @(negedge clk);
    chk({req, " head valid"}, rd_valid, 1);
    chk({req, " head data"}, rd_data, d);
    chk({req, " head fe"}, {rd_fe, csr_rdata[4]}, {fe[0], fe[0]});
    chk({req, " head pe"}, {rd_pe, csr_rdata[2]}, {pe[0], pe[0]});
    pop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", csr_rdata, 8'h20);
    chk("R1 outputs", {rd_valid, tx_out_valid, irq_rxc, irq_txc, irq_udre, irq_dor}, 0);

    // R2 R3 R4 sweep of error-bit combinations through pairs
    for (int c = 0; c < 16; c++) begin
      logic [7:0] d0, d1;
      d0 = 8'(c * 17 + 3);
      d1 = ~d0;
      par_chk_en = c[2];
      rx_put(d0, c[0], c[1]);
      rx_put(d1, c[1], c[0] ^ c[3]);
      @(negedge clk);
      chk("R2 rxc set", csr_rdata[7], 1);
      expect_pop("R3 first", d0, c[0], c[1] & c[2]);
      expect_pop("R4 second", d1, c[1], (c[0] ^ c[3]) & c[2]);
      chk("R2 rxc cleared", {rd_valid, csr_rdata[7]}, 0);
    end
    par_chk_en = 1;

    // R5 R6 overrun sequence
    rx_put(8'h11, 1, 0);
    rx_put(8'h22, 0, 1);
    pulse_start();
    chk("R6 no dor with empty hold", csr_rdata[3], 0);
    rx_put(8'h33, 1, 1);
    chk("R6 dor before start", csr_rdata[3], 0);
    ie_dor = 1;
    pulse_start();
    chk("R6 dor set", csr_rdata[3], 1);
    chk("R11 irq_dor", irq_dor, 1);
    rx_put(8'h44, 0, 0);
    expect_pop("R5 head after overrun", 8'h11, 1, 0);
    chk("R6 dor cleared by pop", {csr_rdata[3], irq_dor}, 0);
    ie_dor = 0;
    expect_pop("R5 second", 8'h22, 0, 1);
    expect_pop("R5 held byte", 8'h33, 1, 1);
    chk("R5 dropped byte absent", rd_valid, 0);

    // R7 flush
    rx_put(8'h55, 0, 0);
    rx_put(8'h66, 0, 0);
    rx_put(8'h77, 0, 0);
    pulse_start();
    @(negedge clk); rx_en = 0;
    rx_put(8'h88, 0, 0);
    @(negedge clk);
    chk("R7 flushed", {rd_valid, csr_rdata[7], csr_rdata[3]}, 0);
    rx_en = 1;
    @(negedge clk);
    chk("R7 ignored while off", rd_valid, 0);

    // R8 transmit path
    @(negedge clk); tx_wr_data = 8'hA5; tx_wr_valid = 1;
    @(negedge clk); tx_wr_valid = 0;
    chk("R8 udre low", {tx_wr_ready, csr_rdata[5]}, 0);
    chk("R8 out", {tx_out_valid, tx_out_data}, {1'b1, 8'hA5});
    // R9 done while held does not set
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    chk("R9 held no txc", csr_rdata[6], 0);
    @(negedge clk); tx_out_ready = 1;
    @(negedge clk); tx_out_ready = 0;
    chk("R8 udre back", {tx_wr_ready, csr_rdata[5], tx_out_valid}, 3'b110);
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    chk("R9 txc set", csr_rdata[6], 1);
    // R10 clear by acknowledge
    @(negedge clk); txc_ack = 1;
    @(negedge clk); txc_ack = 0;
    chk("R10 ack clears", csr_rdata[6], 0);
    // R9 set beats clear
    @(negedge clk); tx_done = 1; txc_ack = 1;
    @(negedge clk); tx_done = 0; txc_ack = 0;
    chk("R9 set beats clear", csr_rdata[6], 1);
    // R10 write of zero then of one
    @(negedge clk); csr_wr = 1; csr_wdata = 8'hBF;
    @(negedge clk); csr_wr = 0;
    chk("R10 write zero keeps", csr_rdata, 8'h60);
    @(negedge clk); csr_wr = 1; csr_wdata = 8'h40;
    @(negedge clk); csr_wr = 0;
    chk("R10 write one clears", csr_rdata, 8'h20);

    // R11 enable sweep with rxc=1, txc=1, udre=1, dor=0
    rx_put(8'h99, 0, 0);
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    for (int e = 0; e < 16; e++) begin
      @(negedge clk);
      {ie_dor, ie_udre, ie_txc, ie_rxc} = 4'(e);
      #1;
      chk("R11 irq", {irq_dor, irq_udre, irq_txc, irq_rxc}, e & 4'b0111);
    end
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule